// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets an on-chip master read and write a 32K x 8 asynchronous static RAM through a single-beat valid/ready request port. Each accepted request turns into one memory access. The access is stretched over a whole number of clock cycles, and every count is derived from the clock period and the memory's timing minimums, all of which are parameters. Writes are controlled by the write-enable pulse. Address and chip select are held steady for the whole pulse. The controller drives the shared data bus only inside that pulse.

A read holds chip select and output enable low for the access time. The returned byte is captured in the last cycle of that window and presented with a one-cycle response strobe. After every read, the controller stays idle long enough for the memory's outputs to float before it can drive the bus again. All memory-side controls are registered. Reset leaves the memory deselected and the bus released.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, chip select, write enable and output enable are high, the bus output enable is low and the response strobe is low. `req_ready` is high once the synchronised reset has been released.
- R2: A write holds chip select and write enable low together for exactly WLEN cycles, with output enable high throughout. WLEN is the larger of ceil(tWP/P) and ceil(tDW/P)+1, where each count is a ceiling with a floor of one cycle. With the default parameters, WLEN = 6.
- R3: The address and chip select do not change during a write pulse.
- R4: The controller drives the bus only from the second cycle of the write pulse through its last cycle. It releases the bus on the same edge where write enable rises, and it never drives while output enable is low.
- R5: The byte stored is the request's write data, presented on the bus for WLEN-1 cycles before the pulse ends (5 cycles by default).
- R6: A read holds chip select and output enable low, with write enable high, for RLEN cycles. RLEN is the largest of ceil(tAA/P), ceil(tOE/P) and ceil(tRC/P), which is 7 by default. The bus value sampled in the last cycle appears on `rsp_rdata` together with `rsp_valid` in the next cycle, which is RLEN cycles after acceptance.
- R7: `rsp_valid` is a single-cycle pulse, issued exactly once per read.
- R8: After each read, the controller stays deselected and not ready for HZ = ceil(tHZ/P) cycles (3 by default). The bus is not driven within HZ cycles of output enable rising.
- R9: `req_ready` is high only when the controller is idle. It is low whenever chip select is low.
- R10: After a write pulse, the controller stays deselected for TAIL = max(1, ceil(tWC/P) - WLEN) cycles, so that successive chip-select falls are at least ceil(tWC/P) cycles apart. By default a write returns to ready 7 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 15 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | 8 | Sampled data bus |

## Verification
The hardest situation to reach is a write that is requested the very first cycle the controller becomes ready after a read. In that case, the turnaround gap is the only thing standing between the controller's driver and a memory output that is still floating. The bench issues every operation at the first negedge where ready is high, so random read-then-write pairs hit this case repeatedly. Its memory model keeps a float-time counter after output enable rises and flags any overlapping drive.

The same model returns inverted data if the controller samples before the access time has elapsed. It also records address movement during a write pulse, so an early capture or a shifted address shows up as a data miscompare.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WPULSE = 3'd1,
    ST_WTAIL  = 3'd2,
    ST_RACC   = 3'd3,
    ST_TURN   = 3'd4
  } asram_state_e;

  // ceiling of t_ns / per_ns, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                            input int unsigned per_ns);
    int unsigned c;
    c = (t_ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int unsigned WLEN  = 6,
  parameter int unsigned TAIL  = 1,
  parameter int unsigned RLEN  = 7,
  parameter int unsigned HZ    = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             req_write,
  input  logic             last,
  output asram_state_e     st_q,
  output asram_state_e     st_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          load = 1'b1;
          if (req_write) begin
            st_d     = ST_WPULSE;
            load_val = CNT_W'(WLEN - 1);
          end else begin
            st_d     = ST_RACC;
            load_val = CNT_W'(RLEN - 1);
          end
        end
      end
      ST_WPULSE: begin
        if (last) begin
          st_d     = ST_WTAIL;
          load     = 1'b1;
          load_val = CNT_W'(TAIL - 1);
        end
      end
      ST_WTAIL: begin
        if (last) st_d = ST_IDLE;
      end
      ST_RACC: begin
        if (last) begin
          st_d     = ST_TURN;
          load     = 1'b1;
          load_val = CNT_W'(HZ - 1);
        end
      end
      ST_TURN: begin
        if (last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  asram_state_e      st_q,
  input  asram_state_e      st_d,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic cs_n_d, we_n_d, oe_n_d, dq_oe_d;

  always_comb begin
    cs_n_d  = !((st_d == ST_WPULSE) || (st_d == ST_RACC));
    we_n_d  = !(st_d == ST_WPULSE);
    oe_n_d  = !(st_d == ST_RACC);
    // drive only once the pulse is already under way, drop as it ends
    dq_oe_d = (st_q == ST_WPULSE) && (st_d == ST_WPULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      cs_n      <= cs_n_d;
      we_n      <= we_n_d;
      oe_n      <= oe_n_d;
      dq_oe     <= dq_oe_d;
      rsp_valid <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      dq_out <= '0;
    end else if (accept) begin
      addr   <= req_addr;
      dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_rdata <= dq_in;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_WP_NS = 55,
  parameter int unsigned T_DW_NS = 30,
  parameter int unsigned T_WC_NS = 70,
  parameter int unsigned T_AA_NS = 70,
  parameter int unsigned T_OE_NS = 35,
  parameter int unsigned T_RC_NS = 70,
  parameter int unsigned T_HZ_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned WP_C  = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int unsigned DW_C  = ns_to_cyc(T_DW_NS, CLK_NS);
  localparam int unsigned WC_C  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned AA_C  = ns_to_cyc(T_AA_NS, CLK_NS);
  localparam int unsigned OE_C  = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int unsigned RC_C  = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int unsigned HZ_C  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned WLEN  = umax(WP_C, DW_C + 1);
  localparam int unsigned TAIL  = (WC_C > WLEN) ? (WC_C - WLEN) : 1;
  localparam int unsigned RLEN  = umax(umax(AA_C, OE_C), RC_C);
  localparam int unsigned MAXC  = umax(umax(WLEN, RLEN), umax(TAIL, HZ_C));
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic         rst_meta_q, rst_sync_n;
  asram_state_e st_q, st_d;
  logic         accept, last, load, capture;
  logic [CNT_W-1:0] load_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign req_ready = rst_sync_n && (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (st_q == ST_RACC) && last;

  asram_fsm #(
    .WLEN (WLEN),
    .TAIL (TAIL),
    .RLEN (RLEN),
    .HZ   (HZ_C),
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .req_write(req_write),
    .last     (last),
    .st_q     (st_q),
    .st_d     (st_d),
    .load     (load),
    .load_val (load_val)
  );

  asram_phase_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load),
    .load_val(load_val),
    .last    (last)
  );

  asram_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .st_q     (st_q),
    .st_d     (st_d),
    .accept   (accept),
    .capture  (capture),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .dq_in    (mem_dq_in),
    .addr     (mem_addr),
    .cs_n     (mem_cs_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_out   (mem_dq_out),
    .dq_oe    (mem_dq_oe),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned WLEN   = 6,
  parameter int unsigned WC_C   = 7,
  parameter int unsigned HZ_C   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr,
  input logic              rsp_valid,
  input logic              req_ready
);

  localparam int unsigned GW = $clog2(WLEN + WC_C + HZ_C + 2) + 1;

  logic [GW-1:0] we_low_q, since_oe_q, since_cs_q;
  logic          cs_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_q   <= '0;
      since_oe_q <= GW'(HZ_C);
      since_cs_q <= GW'(WC_C);
      cs_prev_q  <= 1'b1;
    end else begin
      cs_prev_q <= cs_n;
      if (!we_n) we_low_q <= we_low_q + 1'b1;
      else       we_low_q <= '0;
      if (!oe_n)                       since_oe_q <= '0;
      else if (since_oe_q < GW'(HZ_C)) since_oe_q <= since_oe_q + 1'b1;
      if (cs_prev_q && !cs_n)          since_cs_q <= GW'(1);
      else if (since_cs_q < GW'(WC_C)) since_cs_q <= since_cs_q + 1'b1;
    end
  end

  // R2
  wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_low_q == GW'(WLEN)));
  // R2
  wr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && oe_n));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(addr) && !cs_n));
  // R4
  bus_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && !cs_n && oe_n));
  // R4
  bus_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(!we_n));
  // R6
  rd_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cs_n && we_n && !dq_oe));
  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (since_oe_q >= GW'(HZ_C)));
  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);
  // R10
  cycle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_prev_q && !cs_n) |-> (since_cs_q >= GW'(WC_C)));

endmodule

bind asram_ctrl asram_chk #(
  .ADDR_W(ADDR_W),
  .WLEN  (WLEN),
  .WC_C  (WC_C),
  .HZ_C  (HZ_C)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cs_n     (mem_cs_n),
  .we_n     (mem_we_n),
  .oe_n     (mem_oe_n),
  .dq_oe    (mem_dq_oe),
  .addr     (mem_addr),
  .rsp_valid(rsp_valid),
  .req_ready(req_ready)
);

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;

  localparam int PER      = 10;
  localparam int EXP_WLEN = 6;   // max(ceil(55/10), ceil(30/10)+1)
  localparam int EXP_TAIL = 1;   // max(1, ceil(70/10)-6)
  localparam int EXP_RLEN = 7;   // max(ceil(70/10), ceil(35/10), ceil(70/10))
  localparam int EXP_HZ   = 3;   // ceil(30/10)

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int n_chk = 0;
  int n_bad = 0;

  always #(PER/2) clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  function automatic logic [7:0] init_byte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  // ---------------- memory model ----------------
  logic [7:0] mem   [int];
  logic [7:0] shadow[int];

  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_byte(a);
  endfunction

  int viol_addr = 0, viol_bus = 0, viol_time = 0;
  int wp_cnt, wd_cnt, last_wp, last_wd, rd_cnt, tail;
  bit wp_act = 0, rd_act = 0;
  logic [14:0] wp_addr, rd_addr;
  logic [7:0]  wp_data;

  always @(negedge clk) begin
    bit drv;
    if (!rst_n) begin
      wp_act = 0; rd_act = 0; tail = 0; mem_dq_in = 8'h5A;
    end else begin
      drv = !mem_cs_n && !mem_oe_n && mem_we_n;
      if (mem_dq_oe && (drv || tail > 0)) viol_bus++;
      if (drv) tail = EXP_HZ; else if (tail > 0) tail--;
      if (!mem_cs_n && !mem_we_n) begin
        if (!wp_act) begin
          wp_act = 1; wp_addr = mem_addr; wp_cnt = 0; wd_cnt = 0;
        end else if (mem_addr != wp_addr) viol_addr++;
        wp_cnt++;
        if (mem_dq_oe) begin wd_cnt++; wp_data = mem_dq_out; end
      end else if (wp_act) begin
        wp_act = 0;
        mem[int'(wp_addr)] = wp_data;
        last_wp = wp_cnt; last_wd = wd_cnt;
        if (wd_cnt * PER < 30 || wp_cnt * PER < 55) viol_time++;
      end
      if (drv) begin
        if (!rd_act || mem_addr != rd_addr) begin
          rd_act = 1; rd_addr = mem_addr; rd_cnt = 0;
        end
        rd_cnt++;
        mem_dq_in = (rd_cnt * PER >= 70) ? mem_rd(mem_addr) : ~mem_rd(mem_addr);
      end else begin
        rd_act = 0; mem_dq_in = 8'h5A;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int k, lat_rsp, pulses;
    logic [7:0] got;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    k = 0; lat_rsp = -1; pulses = 0; got = 8'h00;
    while (!req_ready && k < 100) begin
      if (rsp_valid) begin pulses++; lat_rsp = k; got = rsp_rdata; end
      @(negedge clk); k++;
    end
    if (wr) begin
      shadow[int'(a)] = d;
      // R10
      check(k == EXP_WLEN + EXP_TAIL, "R10 write turnaround", k, EXP_WLEN + EXP_TAIL);
      // R2
      check(last_wp == EXP_WLEN, "R2 pulse width", last_wp, EXP_WLEN);
      // R5
      check(last_wd == EXP_WLEN - 1, "R5 data drive span", last_wd, EXP_WLEN - 1);
      check(mem_rd(a) == d, "R5 stored byte", mem_rd(a), d);
    end else begin
      logic [7:0] exp;
      exp = shadow.exists(int'(a)) ? shadow[int'(a)] : init_byte(a);
      // R6
      check(got == exp, "R6 read data", got, exp);
      check(lat_rsp == EXP_RLEN, "R6 response latency", lat_rsp, EXP_RLEN);
      // R7
      check(pulses == 1, "R7 single strobe", pulses, 1);
      // R8 / R9
      check(k == EXP_RLEN + EXP_HZ, "R8 read busy span", k, EXP_RLEN + EXP_HZ);
    end
  endtask

  logic [14:0] pool[8];

  initial begin
    void'($urandom(32'h5eed_0017));
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 controls high in reset",
          {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    check(!mem_dq_oe && !rsp_valid && !req_ready, "R1 bus released in reset",
          {mem_dq_oe, rsp_valid, req_ready}, 3'b000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(req_ready && mem_cs_n && !mem_dq_oe, "R1 idle after release",
          {req_ready, mem_cs_n, mem_dq_oe}, 3'b110);

    // directed corners
    op(1, 15'h0000, 8'hA5);
    op(0, 15'h0000, 8'h00);
    op(1, 15'h7FFF, 8'h3C);
    op(0, 15'h7FFF, 8'h00);
    op(0, 15'h1234, 8'h00);           // never written
    op(0, 15'h0001, 8'h00);           // read directly followed by write: R8
    op(1, 15'h0001, 8'hFF);
    op(1, 15'h0001, 8'h00);           // overwrite
    op(0, 15'h0001, 8'h00);
    op(1, 15'h2AAA, 8'h55);
    op(1, 15'h5555, 8'hAA);
    op(0, 15'h2AAA, 8'h00);
    op(0, 15'h5555, 8'h00);

    for (int i = 0; i < 8; i++) pool[i] = 15'($urandom);
    for (int i = 0; i < 300; i++) begin
      logic [14:0] a;
      a = ($urandom % 4 == 0) ? 15'($urandom) : pool[$urandom % 8];
      op(1'($urandom), a, 8'($urandom));
    end

    // R3
    check(viol_addr == 0, "R3 address moved in pulse", viol_addr, 0);
    // R4
    check(viol_bus == 0, "R4 bus drive overlap", viol_bus, 0);
    // R5
    check(viol_time == 0, "R5 write timing short", viol_time, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule